// File: doc/BRIEF.md
# Programmable Ultrasonic Burst Generator

This block drives an ultrasonic transmitter with a finite train of square-wave pulses. A start strobe captures a divider code, a high-time value, a cycle count and a clock-source select into shadow registers, and the block then emits the requested number of whole cycles. After the low phase of the final cycle, it raises a single-clock completion pulse. The divider code is not a divisor in itself. A computed table maps each of its sixteen values to a period, measured in source ticks.

The source ticks come from one of two places. One is the block's own clock, where every cycle counts as a tick. The other is an alternate tunable clock, presented as a qualifying enable, where only cycles with the enable high count. The high time saturates at one tick below the period, so every cycle keeps a low phase. A cycle count of zero is treated as one. Inputs that change while a burst is running affect only the next burst.

Top module: `burst_gen`

## Requirements
- R1: After reset, `burst_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` high on a clock edge while `busy_o` is low sets `busy_o` high from that edge on and captures all control inputs.
- R3: The period in source ticks is `4 * (div_code_i + 1)`, so codes 0 to 15 give 4 to 64 ticks. A burst keeps `busy_o` high for exactly period times the effective cycle count source ticks.
- R4: With the captured `src_sel_i` = 1, every clock cycle is a source tick. With `src_sel_i` = 0, only cycles with `alt_tick_i` high are ticks.
- R5: Each cycle starts with its high phase. `burst_o` is high for min(`high_i`, period − 1) ticks and low for the rest of the cycle.
- R6: A `cycles_i` of 0 or 1 produces one cycle. A value N from 2 to 255 produces N cycles, each seen as one rising edge of `burst_o`.
- R7: A `high_i` of 0 keeps `burst_o` low for the whole burst, while the cycles are still timed and completion is still signalled.
- R8: `done_o` is high for exactly one clock, in the first cycle after `busy_o` falls.
- R9: A `start_i` while busy is ignored, and input changes during a burst leave the running burst unchanged.
- R10: `burst_o` is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Source select: 1 = block clock, 0 = alternate tick enable |
| alt_tick_i | input | 1 | Tick enable that stands for the alternate tunable clock |
| div_code_i | input | 4 | Divider code, mapped to the period |
| high_i | input | 10 | High time, in source ticks |
| cycles_i | input | 8 | Number of cycles in the burst |
| start_i | input | 1 | Start strobe |
| burst_o | output | 1 | Burst waveform |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps all sixteen divider codes. For each code it uses high times of zero, one, half the period, one below the period, exactly the period and the maximum. It combines these with cycle counts of zero, one and two, and adds a 255-cycle burst. A design that skips the clamp would leave `burst_o` stuck high when the high time equals the period, so the bench would see a rising-edge count of one instead of N. A design that treats a count of zero literally would either never finish or finish without pulsing. Runs in alternate-clock mode use sparse enables and count only qualifying cycles, which exposes any counter that advances on plain clocks. A strobe, together with changed inputs, is injected mid-burst. A design that reloads its shadows would then change the measured period, high time or cycle count.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic [0:0] {
      BST_IDLE = 1'b0,
      BST_RUN  = 1'b1
   } burst_state_e;

   function automatic int unsigned clog2_min1(input int unsigned val);
      int unsigned r;
      r = 1;
      while ((1 << r) < val) r++;
      return r;
   endfunction

endpackage

// File: rtl/burst_div_lut.sv
module burst_div_lut #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned DIV_W    = 10,
   parameter int unsigned DIV_BASE = 4,
   parameter int unsigned DIV_STEP = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DIV_W-1:0]  div_o
);
   localparam int unsigned N_ENT   = 1 << CODE_W;
   localparam int unsigned DIV_TOP = DIV_BASE + DIV_STEP * (N_ENT - 1);

   if (DIV_BASE < 2) begin : g_bad_base
      $error("burst_div_lut: DIV_BASE must be at least 2");
   end
   if (DIV_TOP >= (1 << DIV_W)) begin : g_bad_width
      $error("burst_div_lut: DIV_W too narrow for largest divisor");
   end

   logic [DIV_W-1:0] table_q [N_ENT];

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign table_q[i] = DIV_W'(DIV_BASE + DIV_STEP * i);
   end

   assign div_o = table_q[code_i];
endmodule

// File: rtl/burst_tick_sel.sv
module burst_tick_sel #(
   parameter bit ALT_EN = 1'b1
) (
   input  logic sel_sys_i,
   input  logic alt_tick_i,
   output logic tick_o
);
   if (ALT_EN) begin : g_alt
      assign tick_o = sel_sys_i | alt_tick_i;
   end else begin : g_sys_only
      logic unused_in;
      assign unused_in = sel_sys_i ^ alt_tick_i;
      assign tick_o    = 1'b1;
   end
endmodule

// File: rtl/burst_phase_ctr.sv
module burst_phase_ctr #(
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [DIV_W-1:0] hi_i,
   output logic             wrap_o,
   output logic             high_o
);
   logic [DIV_W-1:0] phase_q;
   logic             at_end;

   assign at_end = (phase_q == div_i - DIV_W'(1));
   assign wrap_o = run_i & tick_i & at_end;
   assign high_o = (phase_q < hi_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (load_i) begin
         phase_q <= '0;
      end else if (run_i && tick_i) begin
         phase_q <= at_end ? '0 : phase_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/burst_cycle_ctl.sv
module burst_cycle_ctl
   import burst_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] cycles_i,
   input  logic             wrap_i,
   output logic             load_o,
   output logic             run_o,
   output logic             done_o
);
   burst_state_e     state_q;
   logic [CNT_W-1:0] left_q;
   logic             done_q;
   logic             last;

   assign load_o = (state_q == BST_IDLE) & start_i;
   assign run_o  = (state_q == BST_RUN);
   assign last   = (left_q == CNT_W'(1));
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BST_IDLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            BST_IDLE: begin
               if (start_i) begin
                  state_q <= BST_RUN;
                  left_q  <= (cycles_i == '0) ? CNT_W'(1) : cycles_i;
               end
            end
            BST_RUN: begin
               if (wrap_i) begin
                  if (last) begin
                     state_q <= BST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     left_q <= left_q - CNT_W'(1);
                  end
               end
            end
            default: state_q <= BST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/burst_gen.sv
module burst_gen #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned DIV_W    = 10,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned DIV_BASE = 4,
   parameter int unsigned DIV_STEP = 4,
   parameter bit          ALT_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_sel_i,
   input  logic              alt_tick_i,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic [DIV_W-1:0]  high_i,
   input  logic [CNT_W-1:0]  cycles_i,
   input  logic              start_i,
   output logic              burst_o,
   output logic              busy_o,
   output logic              done_o
);
   if (CNT_W < 1 || CODE_W < 1) begin : g_bad_param
      $error("burst_gen: widths must be positive");
   end

   logic [DIV_W-1:0] div_lut;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] hi_q;
   logic [DIV_W-1:0] hi_sat;
   logic             sel_q;
   logic             load;
   logic             run;
   logic             tick;
   logic             wrap;
   logic             high;

   burst_div_lut #(
      .CODE_W  (CODE_W),
      .DIV_W   (DIV_W),
      .DIV_BASE(DIV_BASE),
      .DIV_STEP(DIV_STEP)
   ) u_lut (
      .code_i(div_code_i),
      .div_o (div_lut)
   );

   assign hi_sat = (high_i >= div_lut) ? (div_lut - DIV_W'(1)) : high_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(DIV_BASE);
         hi_q  <= '0;
         sel_q <= 1'b1;
      end else if (load) begin
         div_q <= div_lut;
         hi_q  <= hi_sat;
         sel_q <= src_sel_i;
      end
   end

   burst_tick_sel #(.ALT_EN(ALT_EN)) u_tick (
      .sel_sys_i (sel_q),
      .alt_tick_i(alt_tick_i),
      .tick_o    (tick)
   );

   burst_cycle_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .cycles_i(cycles_i),
      .wrap_i  (wrap),
      .load_o  (load),
      .run_o   (run),
      .done_o  (done_o)
   );

   burst_phase_ctr #(.DIV_W(DIV_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .run_i (run),
      .tick_i(tick),
      .div_i (div_q),
      .hi_i  (hi_q),
      .wrap_o(wrap),
      .high_o(high)
   );

   assign busy_o  = run;
   assign burst_o = run & high;
endmodule

// File: rtl/burst_gen_chk.sv
module burst_gen_chk #(
   parameter int unsigned DIV_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             burst_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [DIV_W-1:0] div_q,
   input logic [DIV_W-1:0] hi_q
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !busy_o && !done_o && !burst_o); // R1
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start_i && !busy_o |=> busy_o); // R2
   AST_HIGH_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> hi_q < div_q); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o && $past(busy_o)); // R8
   AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o); // R8
   AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy_o && $past(busy_o) |-> $stable(div_q) && $stable(hi_q)); // R9
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !burst_o); // R10
endmodule

bind burst_gen burst_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .burst_o(burst_o),
   .busy_o (busy_o),
   .done_o (done_o),
   .div_q  (div_q),
   .hi_q   (hi_q)
);

// File: tb/burst_gen_tb.sv
module burst_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_sel = 1'b1;
   logic       alt_tick = 1'b0;
   logic [3:0] div_code = '0;
   logic [9:0] high_val = '0;
   logic [7:0] cyc_val = '0;
   logic       start = 1'b0;
   logic       burst, busy, done;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;

   burst_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_sel_i (src_sel),
      .alt_tick_i(alt_tick),
      .div_code_i(div_code),
      .high_i    (high_val),
      .cycles_i  (cyc_val),
      .start_i   (start),
      .burst_o   (burst),
      .busy_o    (busy),
      .done_o    (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Period from R3 encoding: 4*(code+1) ticks.
   task automatic run(input int code, input int bph, input int cnt, input bit sel,
                      input int per, input bit poke);
      int  div = 4 * (code + 1);
      int  hi  = (bph >= div) ? div - 1 : bph;
      int  n   = (cnt == 0) ? 1 : cnt;
      int  bt = 0, ht = 0, pul = 0, dn = 0, k = 0;
      bit  prev = 1'b0, seen = 1'b0, tk;
      @(negedge clk);
      div_code = 4'(code); high_val = 10'(bph); cyc_val = 8'(cnt);
      src_sel = sel; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
      while (!seen && k < 80000) begin
         alt_tick = ((k % per) == 0);
         if (poke && k == 5) begin
            start = 1'b1; div_code = 4'(code) ^ 4'hF; high_val = 10'd2;
            cyc_val = 8'd7; src_sel = ~sel;
         end else begin
            start = 1'b0;
         end
         tk = sel ? 1'b1 : alt_tick;
         if (busy && tk) bt++;
         if (busy && tk && burst) ht++;
         if (burst && !prev) pul++;
         if (burst && !busy) chk(0, "R10 burst while idle", 1, 0);
         prev = burst;
         if (done) begin dn++; seen = 1'b1; end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      chk(bt == div * n, "R3/R4 busy ticks", bt, div * n);
      chk(ht == hi * n, "R5 high ticks", ht, hi * n);
      chk(pul == ((hi > 0) ? n : 0), "R6/R7 pulse count", pul, (hi > 0) ? n : 0);
      chk(dn == 1 && done === 1'b0, "R8 done width", int'(done), 0);
      chk(busy === 1'b0 && burst === 1'b0, "R10 idle after burst", int'(busy | burst), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1;
      chk(busy === 1'b0 && done === 1'b0 && burst === 1'b0, "R1 reset outputs", int'(busy | done | burst), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(busy === 1'b0 && done === 1'b0 && burst === 1'b0, "R1 outputs after reset", int'(busy | done | burst), 0);
      for (int c = 0; c < 16; c++) begin
         for (int b = 0; b < 6; b++) begin
            for (int n = 0; n < 3; n++) begin
               int d = 4 * (c + 1);
               int bp;
               case (b)
                  0: bp = 0;
                  1: bp = 1;
                  2: bp = d / 2;
                  3: bp = d - 1;
                  4: bp = d;
                  default: bp = 1023;
               endcase
               run(c, bp, n, 1'b1, 1, 1'b0);
            end
         end
      end
      // R4 alternate source with sparse enables
      run(0, 2, 3, 1'b0, 3, 1'b0);
      run(5, 30, 2, 1'b0, 2, 1'b0);
      run(15, 64, 1, 1'b0, 5, 1'b0);
      // R6 full count
      run(0, 1, 255, 1'b1, 1, 1'b0);
      // R9 strobe and changes mid-burst ignored
      run(7, 10, 3, 1'b1, 1, 1'b1);
      run(2, 0, 4, 1'b0, 2, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule